// File: doc/BRIEF.md
# SAR ADC Sequencing Controller

This block sequences a successive-approximation analog-to-digital converter from a small register bank on an APB-style bus. Software programs a power-up wait, then writes the control register with the power bit, a channel number and optionally the interrupt enable. The controller counts the programmed number of clocks, then resolves the result one bit per clock, from the most significant bit down. On each of those clocks it presents a trial code to the external DAC and reads back one comparator bit. When the last bit is decided, the result is stored, busy drops, the interrupt flag is raised, and the interrupt pin follows the flag if it is enabled.

Software acknowledges a result by writing zero to the control register. That write clears the flag, removes converter power and cancels any conversion still in flight. The register bus always completes in its access phase with no wait states, so no back-pressure exists anywhere. The converter pins (`adc_pwr`, `adc_chan`, `dac_code`, `cmp_in`) are plain control levels. A single clock runs both the bus and the converter.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Registers are decoded on `paddr`. 0x0 is the result (bits RES-1:0). 0x4 is status, with bit 0 = busy. 0x8 is control: bits 2:0 channel, bit 3 power, bit 5 interrupt enable, bit 6 interrupt flag. 0xC is the wait count (bits 5:0). Every other bit reads 0, and after reset every register reads 0.
- R2: A control write with bit 3 = 1 while idle starts a conversion. Busy then reads 1 for exactly DLY+1+RES cycles, counted from the clock edge of that write, where DLY is the wait count.
- R3: After the start, the block waits DLY clocks before it places the first trial code. With DLY = 0, the first trial appears on the clock right after the start edge.
- R4: Bits are tried MSB first, one per clock. `dac_code` equals the bits already kept plus the current trial bit. A bit is kept when `cmp_in` = 1. `dac_code` is 0 whenever no bit is being tried.
- R5: The result is written to the data register on the edge that decides the last bit, and busy reads 0 from that same edge. Result bits at and above RES read 0.
- R6: Finishing a conversion sets control bit 6. `irq` is high exactly while bit 6 and bit 5 are both 1.
- R7: A control write with bit 6 = 0 clears the interrupt flag, and a flag set on the same edge wins. A control write with bit 3 = 0 while busy aborts the conversion and leaves the data register unchanged. Writing 0 therefore clears the flag and powers down `adc_pwr`.
- R8: Writes to the data register are ignored. It holds the last completed result.
- R9: `adc_chan` follows the channel field. A written channel above NCH-1 is stored as NCH-1.
- R10: A control write with bit 3 = 1 while busy does not restart the conversion and keeps the channel. The enable, power and flag-clear fields still take effect.
- R11: The wait count register keeps only the 6 low bits of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and converter |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 4 | Byte address of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high |
| irq | output | 1 | Interrupt request |
| adc_pwr | output | 1 | Converter power enable |
| adc_chan | output | 3 | Analog input select |
| dac_code | output | RES | Trial code for the DAC |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above dac_code |

## Verification
The assertions watch the following on every clock:
- An abort always returns the block to idle on the next edge.
- The trial bit index falls by exactly one between consecutive trial clocks.
- `dac_code` is zero whenever the block is idle.
- A finished conversion always leaves the interrupt flag set.
- The data register never changes except on a completion edge.

Only the bench scenarios can show the rest:
- The exact busy length for several wait counts.
- The correctness of the resolved values at zero, full scale and mid codes.
- Channel clamping, the ignored restart, the ignored data write, and the gating of `irq` by the enable.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam logic [3:0] ADDR_RESULT = 4'h0;
  localparam logic [3:0] ADDR_STATUS = 4'h4;
  localparam logic [3:0] ADDR_CTRL   = 4'h8;
  localparam logic [3:0] ADDR_WAIT   = 4'hC;

  localparam int BIT_PWR = 3;
  localparam int BIT_IEN = 5;
  localparam int BIT_FLG = 6;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WAIT = 2'd1,
    PH_CONV = 2'd2
  } phase_t;

  typedef struct packed {
    logic       flag;
    logic       ien;
    logic       pwr;
    logic [2:0] chan;
  } ctrl_t;
endpackage

// File: rtl/sar_regs.sv
module sar_regs
  import sar_pkg::*;
#(
  parameter int RES  = 10,
  parameter int NCH  = 6,
  parameter int DLYW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [3:0]      paddr,
  input  logic [31:0]     pwdata,
  output logic [31:0]     prdata,
  input  logic            busy,
  input  logic            done,
  input  logic [RES-1:0]  result,
  output ctrl_t           ctrl_q,
  output logic [DLYW-1:0] wait_q,
  output logic            start,
  output logic            abort
);
  localparam logic [2:0] CH_MAX = 3'(NCH - 1);

  logic           wr_en;
  logic           ctrl_wr;
  logic [2:0]     chan_in;
  logic [RES-1:0] data_q;

  assign wr_en   = psel & penable & pwrite;
  assign ctrl_wr = wr_en && (paddr == ADDR_CTRL);
  assign start   = ctrl_wr && pwdata[BIT_PWR] && !busy;
  assign abort   = ctrl_wr && !pwdata[BIT_PWR] && busy;
  assign chan_in = (pwdata[2:0] > CH_MAX) ? CH_MAX : pwdata[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.pwr <= pwdata[BIT_PWR];
        ctrl_q.ien <= pwdata[BIT_IEN];
        if (!(busy && pwdata[BIT_PWR])) ctrl_q.chan <= chan_in;
        if (!pwdata[BIT_FLG]) ctrl_q.flag <= 1'b0;
      end
      if (done) ctrl_q.flag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
    end else if (wr_en && (paddr == ADDR_WAIT)) begin
      wait_q <= pwdata[DLYW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (done) begin
      data_q <= result;
    end
  end

  always_comb begin
    prdata = '0;
    unique case (paddr)
      ADDR_RESULT: prdata = {{(32-RES){1'b0}}, data_q};
      ADDR_STATUS: prdata = {31'b0, busy};
      ADDR_CTRL:   prdata = {25'b0, ctrl_q.flag, ctrl_q.ien, 1'b0, ctrl_q.pwr, ctrl_q.chan};
      ADDR_WAIT:   prdata = {{(32-DLYW){1'b0}}, wait_q};
      default:     prdata = '0;
    endcase
  end

  p_done_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ctrl_q.flag);

  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(done) |-> $stable(data_q));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int RES  = 10,
  parameter int DLYW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            abort,
  input  logic [DLYW-1:0] wait_cnt,
  input  logic            cmp_in,
  output logic            busy,
  output logic            done,
  output logic [RES-1:0]  dac_code,
  output logic [RES-1:0]  result
);
  localparam int IDXW = (RES > 1) ? $clog2(RES) : 1;
  localparam logic [IDXW-1:0] MSB_IDX = IDXW'(RES - 1);

  phase_t          phase;
  logic [DLYW-1:0] cnt;
  logic [IDXW-1:0] idx;
  logic [RES-1:0]  acc;
  logic [RES-1:0]  trial_bit;
  logic [RES-1:0]  trial;

  assign trial_bit = RES'(1) << idx;
  assign trial     = acc | trial_bit;
  assign busy      = (phase != PH_IDLE);
  assign done      = (phase == PH_CONV) && (idx == '0) && !abort;
  assign dac_code  = (phase == PH_CONV) ? trial : '0;
  assign result    = cmp_in ? trial : acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      idx   <= '0;
      acc   <= '0;
    end else if (abort) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_WAIT;
            cnt   <= wait_cnt;
          end
        end
        PH_WAIT: begin
          if (cnt == '0) begin
            phase <= PH_CONV;
            idx   <= MSB_IDX;
            acc   <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_CONV: begin
          acc <= result;
          if (idx == '0) phase <= PH_IDLE;
          else           idx   <= idx - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  p_abort_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

  p_idx_descends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CONV && $past(phase) == PH_CONV) |-> idx == $past(idx) - 1'b1);

  p_dac_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dac_code == '0);
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int RES  = 10,
  parameter int NCH  = 6,
  parameter int DLYW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           psel,
  input  logic           penable,
  input  logic           pwrite,
  input  logic [3:0]     paddr,
  input  logic [31:0]    pwdata,
  output logic [31:0]    prdata,
  output logic           irq,
  output logic           adc_pwr,
  output logic [2:0]     adc_chan,
  output logic [RES-1:0] dac_code,
  input  logic           cmp_in
);
  ctrl_t           ctrl_q;
  logic [DLYW-1:0] wait_q;
  logic            start;
  logic            abort;
  logic            busy;
  logic            done;
  logic [RES-1:0]  result;

  sar_regs #(.RES(RES), .NCH(NCH), .DLYW(DLYW)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .busy(busy), .done(done),
    .result(result), .ctrl_q(ctrl_q), .wait_q(wait_q), .start(start), .abort(abort)
  );

  sar_seq #(.RES(RES), .DLYW(DLYW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .wait_cnt(wait_q),
    .cmp_in(cmp_in), .busy(busy), .done(done), .dac_code(dac_code), .result(result)
  );

  assign irq      = ctrl_q.flag & ctrl_q.ien;
  assign adc_pwr  = ctrl_q.pwr;
  assign adc_chan = ctrl_q.chan;
endmodule

// File: tb/tb_sar_adc_ctrl.sv
module tb_sar_adc_ctrl;
  localparam int RES = 10;
  localparam int NCH = 6;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [3:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic irq, adc_pwr, cmp_in;
  logic [2:0] adc_chan;
  logic [RES-1:0] dac_code;

  int vin [8];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // behavioural reference state
  bit m_busy, m_ist, m_ien, m_pwr;
  int m_rem, m_chan, m_dly, m_data;

  always #5 clk = ~clk;

  assign cmp_in = (int'(dac_code) <= vin[adc_chan]);

  sar_adc_ctrl #(.RES(RES), .NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq), .adc_pwr(adc_pwr),
    .adc_chan(adc_chan), .dac_code(dac_code), .cmp_in(cmp_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_ist = 0; m_ien = 0; m_pwr = 0;
      m_rem = 0; m_chan = 0; m_dly = 0; m_data = 0;
    end else begin
      bit wr, pre, done, abrt;
      wr = psel && penable && pwrite;
      pre = m_busy;
      done = 0;
      abrt = wr && paddr == 4'h8 && !pwdata[3] && pre;
      if (pre && !abrt) begin
        m_rem--;
        if (m_rem == 0) begin
          m_busy = 0; done = 1;
          m_data = vin[m_chan] > 1023 ? 1023 : vin[m_chan];
        end
      end
      if (abrt) m_busy = 0;
      if (wr && paddr == 4'h8) begin
        if (!(pre && pwdata[3])) m_chan = pwdata[2:0] > NCH-1 ? NCH-1 : int'(pwdata[2:0]);
        m_pwr = pwdata[3];
        m_ien = pwdata[5];
        if (!pwdata[6]) m_ist = 0;
        if (pwdata[3] && !pre) begin m_busy = 1; m_rem = m_dly + 1 + RES; end
      end
      if (done) m_ist = 1;
      if (wr && paddr == 4'hC) m_dly = int'(pwdata[5:0]);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(irq == (m_ist && m_ien), "R6 irq pin", irq, m_ist && m_ien);
      chk(adc_pwr == m_pwr, "R7 power pin", adc_pwr, m_pwr);
      chk(adc_chan == m_chan, "R9 channel pin", adc_chan, m_chan);
      chk((dac_code != 0) == (m_busy && m_rem <= RES), "R4 trial activity", dac_code, m_busy && m_rem <= RES);
    end
  end

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  function automatic logic [31:0] model_val(input logic [3:0] a);
    case (a)
      4'h0: return 32'(m_data);
      4'h4: return {31'b0, m_busy};
      4'h8: return {25'b0, m_ist, m_ien, 1'b0, m_pwr, 3'(m_chan)};
      4'hC: return 32'(m_dly);
      default: return 0;
    endcase
  endfunction

  task automatic bus_rd(input logic [3:0] a, input string tag, output logic [31:0] v);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1;
    v = prdata;
    chk(v == model_val(a), tag, v, model_val(a));
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 100; i++) begin
      bus_rd(4'h4, tag, v);
      if (v[0] == 0) break;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    vin = '{0, 0, 0, 0, 0, 0, 0, 0};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    bus_rd(4'h0, "R1 reset data", v);
    bus_rd(4'h4, "R1 reset status", v);
    bus_rd(4'h8, "R1 reset ctrl", v);
    bus_rd(4'hC, "R1 reset wait", v);
    // R2 R3 R5 typical conversion with wait 8
    vin[0] = 'h2AA;
    bus_wr(4'hC, 8);
    bus_wr(4'h8, 32'h28);
    wait_idle("R2 busy length wait 8");
    bus_rd(4'h0, "R5 result mid code", v);
    bus_rd(4'h8, "R6 flag set", v);
    // R7 clear
    bus_wr(4'h8, 0);
    bus_rd(4'h8, "R7 clear by zero", v);
    // R3 wait 0 at full scale
    vin[3] = 1023;
    bus_wr(4'hC, 0);
    bus_wr(4'h8, 32'h2B);
    wait_idle("R3 busy length wait 0");
    bus_rd(4'h0, "R4 full scale", v);
    bus_wr(4'h8, 0);
    // R11 wait width, R6 interrupt disabled, zero input
    bus_wr(4'hC, 32'hFF);
    bus_rd(4'hC, "R11 wait truncation", v);
    vin[5] = 0;
    bus_wr(4'h8, 32'h0D);
    wait_idle("R2 busy length wait 63");
    bus_rd(4'h0, "R4 zero input", v);
    bus_rd(4'h8, "R6 flag without enable", v);
    // R7 flag kept by write with bit6 set
    bus_wr(4'h8, 32'h45);
    bus_rd(4'h8, "R7 flag kept", v);
    bus_wr(4'h8, 0);
    // R8 data write ignored
    vin[4] = 'h155;
    bus_wr(4'hC, 2);
    bus_wr(4'h8, 32'h2C);
    wait_idle("R2 busy length wait 2");
    bus_wr(4'h0, 32'h123);
    bus_rd(4'h0, "R8 data write ignored", v);
    bus_wr(4'h8, 0);
    // R7 abort mid conversion
    vin[1] = 512;
    bus_wr(4'hC, 8);
    bus_wr(4'h8, 32'h29);
    repeat (12) @(negedge clk);
    bus_wr(4'h8, 0);
    bus_rd(4'h4, "R7 abort clears busy", v);
    bus_rd(4'h0, "R7 abort keeps data", v);
    // R10 restart ignored while busy
    vin[2] = 77;
    bus_wr(4'h8, 32'h2A);
    repeat (4) @(negedge clk);
    bus_wr(4'h8, 32'h0C);
    bus_rd(4'h8, "R10 channel held", v);
    wait_idle("R10 no restart");
    bus_rd(4'h0, "R10 result of first channel", v);
    // R9 channel clamp
    bus_wr(4'h8, 32'h07);
    bus_rd(4'h8, "R9 channel clamp", v);
    bus_wr(4'h8, 0);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule